// File: doc/BRIEF.md
# Toggle-Started Percentage PWM Generator

This block produces a pulse-width-modulated waveform with a fixed period of one hundred time-base ticks. With the default settings one tick lasts 1 ms, so the period is 100 ms, a 10 Hz wave. A 7-bit unsigned input sets the duty cycle as a whole percentage. A value of 0 keeps the wave low and a value of 100 keeps it high. Values above 100 are treated as 100.

An internal prescaler divides the system clock down to the tick strobe. One down counter times both phases of every period. A five-state sequencer loads the counter with the on-time and counts it down once per tick. It then loads the counter with the off-time, which is the period minus the on-time, and counts that down the same way. The duty input is read only when the on-time is loaded, so a new value takes effect from the next period.

A push-button input starts and stops the generator. The button is synchronised to the clock and edge-detected, so each press flips the run state once. A status LED output is on while the generator runs. When the generator stops, the sequencer returns to idle and the wave goes low. The prescaler needs at least three clocks per tick. A load step then never falls on a tick cycle, and each phase lasts exactly its tick count times the prescaler ratio.

Top module: `pwm_toggle_gen`

## Requirements
- R1: After reset, wave_o and run_led_o are both 0.
- R2: Each rising edge of start_btn_i flips run_led_o exactly once, a fixed few clocks later. A button held high does not flip it again.
- R3: While running with duty D (1 to 99), each high interval of wave_o lasts D*TICK_DIV clocks and each low interval lasts (100-D)*TICK_DIV clocks.
- R4: While running with duty 0, wave_o stays 0 for the whole period. No one-tick pulse appears.
- R5: While running with duty 100, wave_o stays 1 for the whole period. No one-tick gap appears.
- R6: A duty input above 100 (101 to 127) produces the same output as 100.
- R7: The duty input is read only at the start of a period. If it changes during a high phase, that high phase and the low phase after it keep the old value, and the next period uses the new value.
- R8: One clock after run_led_o is 0, wave_o is 0, and it stays 0 while the generator is stopped. A later press restarts normal output.
- R9: The phase counter changes only on a tick strobe. Ticks arrive every TICK_DIV clocks, so a duty of 1 gives a high interval of exactly TICK_DIV clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_i | input | DUTY_W (7) | Duty cycle in percent, unsigned; 0 to 100, larger values clamp to 100 |
| start_btn_i | input | 1 | Start/stop push button, asynchronous, assumed already debounced |
| wave_o | output | 1 | PWM waveform |
| run_led_o | output | 1 | High while the generator is running |

## Verification
The bench builds the block with TICK_DIV of 4, keeping the default of one hundred ticks per period and a 7-bit duty. A full period is then 400 clocks. Many periods fit in a short run, and the clock-exact lengths of the high and low intervals can be compared against the duty times four. The small ratio also puts the load steps within two clocks of a tick. That exercises the zero-length-phase skips at 0% and 100%, and checks that no tick is lost next to a load.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_LOAD_ON   = 3'd1,
    ST_COUNT_ON  = 3'd2,
    ST_LOAD_OFF  = 3'd3,
    ST_COUNT_OFF = 3'd4
  } pwm_state_e;

  // Duty request limited to the number of ticks in one period.
  function automatic int unsigned clamp_pct(input int unsigned raw, input int unsigned full);
    return (raw > full) ? full : raw;
  endfunction

  // Ticks left for the low phase once the high phase is known.
  function automatic int unsigned low_ticks(input int unsigned high, input int unsigned full);
    return full - high;
  endfunction

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int unsigned TICK_DIV = 250000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (div_q == LAST) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign tick_o = (div_q == LAST);
endmodule

// File: rtl/pwm_start_toggle.sv
module pwm_start_toggle #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_i,
  output logic press_o,
  output logic run_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   run_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= btn_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], btn_i};
      end
    end
  endgenerate

  assign press_o = sync_q[SYNC_STAGES-1] & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      prev_q <= sync_q[SYNC_STAGES-1];
      if (press_o) run_q <= ~run_q;
    end
  end

  assign run_o = run_q;
endmodule

// File: rtl/pwm_phase_fsm.sv
module pwm_phase_fsm
  import pwm_pkg::*;
#(
  parameter int unsigned DUTY_W       = 7,
  parameter int unsigned PERIOD_TICKS = 100,
  parameter int unsigned CNT_W        = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              wave_o,
  output pwm_state_e        state_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              load_on_o,
  output logic              load_off_o
);
  pwm_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] on_q;
  logic             wave_q;
  logic [CNT_W-1:0] duty_c;
  logic [CNT_W-1:0] off_c;

  always_comb begin
    duty_c = CNT_W'(clamp_pct(32'(duty_i), PERIOD_TICKS));
    off_c  = CNT_W'(low_ticks(32'(on_q), PERIOD_TICKS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      on_q    <= '0;
      wave_q  <= 1'b0;
    end else if (!run_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wave_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: state_q <= ST_LOAD_ON;
        ST_LOAD_ON: begin
          on_q  <= duty_c;
          cnt_q <= duty_c;
          if (duty_c == '0) begin
            state_q <= ST_LOAD_OFF;
          end else begin
            state_q <= ST_COUNT_ON;
            wave_q  <= 1'b1;
          end
        end
        ST_COUNT_ON: if (tick_i) begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) state_q <= ST_LOAD_OFF;
        end
        ST_LOAD_OFF: begin
          cnt_q <= off_c;
          if (off_c == '0) begin
            state_q <= ST_LOAD_ON;
          end else begin
            state_q <= ST_COUNT_OFF;
            wave_q  <= 1'b0;
          end
        end
        ST_COUNT_OFF: if (tick_i) begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) state_q <= ST_LOAD_ON;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wave_o     = wave_q;
  assign state_o    = state_q;
  assign cnt_o      = cnt_q;
  assign load_on_o  = (state_q == ST_LOAD_ON);
  assign load_off_o = (state_q == ST_LOAD_OFF);
endmodule

// File: rtl/pwm_toggle_gen.sv
module pwm_toggle_gen
  import pwm_pkg::*;
#(
  parameter int unsigned DUTY_W       = 7,
  parameter int unsigned PERIOD_TICKS = 100,
  parameter int unsigned TICK_DIV     = 250000,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              start_btn_i,
  output logic              wave_o,
  output logic              run_led_o
);
  localparam int unsigned CNT_W = $clog2(PERIOD_TICKS + 1);

  // Internal events, named for the checker.
  logic             tick_w;
  logic             press_w;
  logic             run_w;
  pwm_state_e       state_w;
  logic [CNT_W-1:0] cnt_w;
  logic             load_on_w;
  logic             load_off_w;

  pwm_tick_gen #(.TICK_DIV(TICK_DIV)) tick_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick_w)
  );

  pwm_start_toggle #(.SYNC_STAGES(SYNC_STAGES)) start_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .btn_i   (start_btn_i),
    .press_o (press_w),
    .run_o   (run_w)
  );

  pwm_phase_fsm #(
    .DUTY_W       (DUTY_W),
    .PERIOD_TICKS (PERIOD_TICKS),
    .CNT_W        (CNT_W)
  ) fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run_w),
    .tick_i     (tick_w),
    .duty_i     (duty_i),
    .wave_o     (wave_o),
    .state_o    (state_w),
    .cnt_o      (cnt_w),
    .load_on_o  (load_on_w),
    .load_off_o (load_off_w)
  );

  assign run_led_o = run_w;
endmodule

// File: rtl/pwm_toggle_gen_chk.sv
module pwm_toggle_gen_chk
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wave_o,
  input logic             run_led_o,
  input logic             tick_w,
  input logic             press_w,
  input logic             run_w,
  input pwm_state_e       state_w,
  input logic [CNT_W-1:0] cnt_w,
  input logic             load_on_w,
  input logic             load_off_w
);
  logic counting;
  assign counting = (state_w == ST_COUNT_ON) || (state_w == ST_COUNT_OFF);

  assert_reset_low_R1: assert property (@(posedge clk) !rst_n |-> (!wave_o && !run_led_o));

  assert_led_by_press_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_led_o != $past(run_led_o)) |-> $past(press_w));

  assert_rise_after_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wave_o) |-> $past(load_on_w));

  assert_fall_after_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wave_o) |-> ($past(load_off_w) || !$past(run_w)));

  assert_count_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    counting |-> (cnt_w != '0));

  assert_stop_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_led_o |=> !wave_o);

  assert_hold_between_ticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && !tick_w && run_w) |=> $stable(cnt_w));

  assert_tick_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick_w |=> !tick_w);
endmodule

bind pwm_toggle_gen pwm_toggle_gen_chk #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .wave_o     (wave_o),
  .run_led_o  (run_led_o),
  .tick_w     (tick_w),
  .press_w    (press_w),
  .run_w      (run_w),
  .state_w    (state_w),
  .cnt_w      (cnt_w),
  .load_on_w  (load_on_w),
  .load_off_w (load_off_w)
);

// File: tb/pwm_toggle_gen_tb_top.sv
module pwm_toggle_gen_tb_top;
  localparam int unsigned TICK = 4;
  localparam int unsigned FULL = 100;
  localparam int unsigned PER  = FULL * TICK;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] duty = 7'd0;
  logic       btn = 1'b0;
  logic       wave;
  logic       led;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  pwm_toggle_gen #(.TICK_DIV(TICK)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .duty_i      (duty),
    .start_btn_i (btn),
    .wave_o      (wave),
    .run_led_o   (led)
  );

  function automatic int exp_high(input int d);
    return ((d > 100) ? 100 : d) * TICK;
  endfunction

  function automatic int exp_low(input int d);
    return PER - exp_high(d);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic press();
    @(negedge clk) btn = 1'b1;
    repeat (3) @(negedge clk);
    btn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Advance to the first negedge where wave is high after having been low.
  task automatic wait_rise();
    int guard = 0;
    while (wave == 1'b1 && guard < 3 * PER) begin @(negedge clk); guard++; end
    while (wave == 1'b0 && guard < 3 * PER) begin @(negedge clk); guard++; end
  endtask

  task automatic count_level(input logic lvl, inout int n);
    while (wave == lvl && n < 3 * PER) begin n++; @(negedge clk); end
  endtask

  task automatic sample_highs(input int cycles, output int highs);
    highs = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (wave) highs++;
    end
  endtask

  task automatic measure_duty(input int d, input string req);
    int hi = 0;
    int lo = 0;
    duty = 7'(d);
    wait_rise();
    count_level(1'b1, hi);
    count_level(1'b0, lo);
    check({req, " high"}, hi, exp_high(d));
    check({req, " low"}, lo, exp_low(d));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int highs;
    int hi;
    int lo;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    check("R1 wave", int'(wave), 0);
    check("R1 led", int'(led), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 wave after release", int'(wave), 0);

    // R2: one press flips the LED, a long hold does not flip it again
    duty = 7'd50;
    @(negedge clk) btn = 1'b1;
    repeat (40) @(negedge clk);
    check("R2 led after held press", int'(led), 1);
    btn = 1'b0;
    repeat (4) @(negedge clk);
    check("R2 led after release", int'(led), 1);

    // R3: directed and random duties
    measure_duty(50, "R3 d=50");
    measure_duty(99, "R3 d=99");
    for (int k = 0; k < 8; k++) begin
      int d = int'($urandom_range(98, 2));
      measure_duty(d, "R3 random");
    end
    // R9: one tick of on-time is exactly TICK_DIV clocks
    measure_duty(1, "R9 d=1");

    // R4: 0% is flat low
    duty = 7'd0;
    repeat (2 * PER) @(negedge clk);
    sample_highs(2 * PER, highs);
    check("R4 highs at 0%", highs, 0);

    // R5: 100% is flat high
    duty = 7'd100;
    repeat (2 * PER) @(negedge clk);
    sample_highs(2 * PER, highs);
    check("R5 highs at 100%", highs, 2 * PER);

    // R6: clamp above 100
    duty = 7'd127;
    repeat (2 * PER) @(negedge clk);
    sample_highs(2 * PER, highs);
    check("R6 highs at 127", highs, 2 * PER);
    duty = 7'd101;
    repeat (PER) @(negedge clk);
    sample_highs(2 * PER, highs);
    check("R6 highs at 101", highs, 2 * PER);

    // R7: change during a high phase applies to the next period only
    duty = 7'd30;
    wait_rise();
    wait_rise();
    hi = 0;
    for (int i = 0; i < 10; i++) begin hi++; @(negedge clk); end
    duty = 7'd70;
    count_level(1'b1, hi);
    lo = 0;
    count_level(1'b0, lo);
    check("R7 current high keeps old duty", hi, exp_high(30));
    check("R7 following low keeps old duty", lo, exp_low(30));
    hi = 0;
    count_level(1'b1, hi);
    check("R7 next high uses new duty", hi, exp_high(70));

    // R8: stop forces low, restart resumes
    duty = 7'd60;
    wait_rise();
    repeat (20) @(negedge clk);
    press();
    check("R8 led off", int'(led), 0);
    check("R8 wave low after stop", int'(wave), 0);
    sample_highs(PER + 50, highs);
    check("R8 stays low while stopped", highs, 0);
    press();
    check("R2 led on after second press", int'(led), 1);
    measure_duty(60, "R8 restart");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule